// File: doc/BRIEF.md
# Paced Multichannel Acquisition Sequencer

This block paces a multichannel data-acquisition front end. A free-running pacer counter divides the system clock by a programmable 32-bit value plus one. Each time the counter rolls over, the sequencer starts one scan. A scan walks a programmable list of up to eight channel entries and sends one conversion request per entry to the converter. It waits for the converter's done pulse before it moves to the next entry.

A minimum spacing of `GAP_CYC` clocks between any two requests enforces the per-sample ceiling. At 40 MHz with the default of 400 clocks, that ceiling is 100 kHz. A divider of zero is the fastest legal mode: scans then run back to back, limited only by that ceiling. A rollover that lands while a scan is still running is dropped and recorded in a sticky overrun flag.

All channels share a single write offset into a 4 kB sample buffer. The offset advances once per completed scan and wraps to zero. On each wrap, the sequencer raises a sticky status bit for every channel in the list. The interrupt line is driven from those status bits, gated by a per-channel enable mask. Software reaches six registers through a simple write port with a combinational read mux.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, every register reads 0: CTRL at address 0, LIST at 1, DIV at 2, STAT at 3, IEN at 4 and OFS at 5. After reset, `conv_req` and `irq` are low and `buf_offset` is 0.
- R2: Writing CTRL with bit 0 (run) set while stopped starts sampling at that write edge E. The first request is visible after edge E+DIV+2, and successive scans start DIV+1 cycles apart.
- R3: A write to DIV while run is set leaves DIV unchanged. A write to DIV while stopped takes effect.
- R4: `conv_req` is a one-cycle pulse, and two pulses are never closer than `GAP_CYC` cycles. Within a scan, when done returns one cycle after the request, requests are exactly `GAP_CYC` cycles apart.
- R5: A scan issues entries 0 to LAST in order, where LAST is CTRL bits [6:4]. For entry k, `conv_ch` carries LIST bits [3k+2:3k].
- R6: With DIV = 0, scans follow one another with requests exactly `GAP_CYC` apart, and no overrun is flagged.
- R7: With DIV nonzero, a rollover that arrives during a scan is dropped and sets STAT bit 8. That bit stays set until a 1 is written to it.
- R8: `buf_offset` (also readable at OFS) rises by exactly 1 per completed scan and wraps from 2^OFS_W-1 to 0.
- R9: When the offset wraps, STAT bit c is set for every channel id c held in entries 0 to LAST. Writing 1 to a STAT bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some STAT bit c (c in 0..7) and IEN bit c are both set.
- R11: Each start clears the pacer count and the list index. A restart during a scan therefore begins again at entry 0, DIV+2 cycles after the start edge.
- R12: Clearing run abandons any scan in progress. No request appears from the second cycle after the stop write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 3 | Channel id for the current request |
| conv_done | input | 1 | Conversion complete pulse |
| buf_offset | output | OFS_W | Shared buffer write offset |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the next rising edge. Reads are combinational, so the bench samples read data and `irq` at the falling edge that follows the write task. The first request after a start edge E is expected at E+DIV+2: one edge clears the count, DIV+1 edges bring the rollover, and one more edge registers the request. Each falling-edge sample is compared against that figure. Status bits appear one cycle after the offset wraps, so the bench reads STAT only a few cycles after it sees the wrap.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 3'd0,
        ADR_LIST = 3'd1,
        ADR_DIV  = 3'd2,
        ADR_STAT = 3'd3,
        ADR_IEN  = 3'd4,
        ADR_OFS  = 3'd5
    } reg_sel_e;

    localparam int RUN_BIT  = 0;
    localparam int LAST_LSB = 4;
    localparam int OVR_BIT  = 8;

    // events raised by the scan engine toward the register file
    typedef struct packed {
        logic wrap;
        logic ovr;
    } scan_evt_t;

    function automatic logic sel_hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
        return a == s;
    endfunction
endpackage

// File: rtl/acq_pacer.sv
module acq_pacer #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    output logic             trig
);
    logic [DIV_W-1:0] cnt_q;

    assign trig = run && !start && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || start || trig) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/acq_scan.sv
module acq_scan
    import acq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int CH_W    = 3,
    parameter int GAP_CYC = 400,
    parameter int OFS_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   start,
    input  logic                   trig,
    input  logic                   div_zero,
    input  logic [CH_W-1:0]        last,
    input  logic [NUM_CH*CH_W-1:0] list,
    input  logic                   conv_done,
    output logic                   conv_req,
    output logic [CH_W-1:0]        conv_ch,
    output logic [OFS_W-1:0]       ofs,
    output scan_evt_t              evt
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC - 1);

    logic              busy_q, wait_q;
    logic [CH_W-1:0]   idx_q;
    logic [GAP_W-1:0]  gap_q;
    logic              active, issue, finish;

    assign active = run && !start;
    assign issue  = active && busy_q && !wait_q && (gap_q == '0);
    assign finish = active && busy_q && wait_q && conv_done && (idx_q == last);

    // spacing counter survives stop/start so the sample ceiling always holds
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (issue) begin
            gap_q <= GAP_LOAD;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            wait_q   <= 1'b0;
            idx_q    <= '0;
            conv_req <= 1'b0;
            conv_ch  <= '0;
            evt      <= '0;
        end else begin
            conv_req <= issue;
            evt.ovr  <= active && trig && busy_q && !div_zero;
            evt.wrap <= finish && (&ofs);
            if (!active) begin
                busy_q <= 1'b0;
                wait_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                if (trig && !busy_q) begin
                    busy_q <= 1'b1;
                    idx_q  <= '0;
                end
                if (issue) begin
                    conv_ch <= list[idx_q*CH_W +: CH_W];
                    wait_q  <= 1'b1;
                end
                if (busy_q && wait_q && conv_done) begin
                    wait_q <= 1'b0;
                    if (idx_q == last) begin
                        busy_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs <= '0;
        end else if (finish) begin
            ofs <= ofs + 1'b1;
        end
    end
endmodule

// File: rtl/acq_regs.sv
module acq_regs
    import acq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int DIV_W  = 32,
    parameter int OFS_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [OFS_W-1:0]       ofs,
    input  scan_evt_t              evt,
    output logic                   run,
    output logic                   start,
    output logic [CH_W-1:0]        last,
    output logic [NUM_CH*CH_W-1:0] list,
    output logic [DIV_W-1:0]       div,
    output logic                   irq
);
    localparam int LIST_W = NUM_CH * CH_W;

    logic [NUM_CH-1:0] stat_q, ien_q, set_mask, clr_mask;
    logic              ovr_q;
    logic              wr_ctrl, wr_list, wr_div, wr_stat, wr_ien;
    logic              unused_bits;

    assign unused_bits = ^reg_wdata;

    assign wr_ctrl = reg_wr && sel_hit(reg_addr, ADR_CTRL);
    assign wr_list = reg_wr && sel_hit(reg_addr, ADR_LIST);
    assign wr_div  = reg_wr && sel_hit(reg_addr, ADR_DIV);
    assign wr_stat = reg_wr && sel_hit(reg_addr, ADR_STAT);
    assign wr_ien  = reg_wr && sel_hit(reg_addr, ADR_IEN);
    assign start   = wr_ctrl && reg_wdata[RUN_BIT] && !run;

    always_comb begin
        set_mask = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (k <= int'(last)) set_mask[list[k*CH_W +: CH_W]] = 1'b1;
        end
    end

    assign clr_mask = wr_stat ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            last   <= '0;
            list   <= '0;
            div    <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run  <= reg_wdata[RUN_BIT];
                last <= reg_wdata[LAST_LSB +: CH_W];
            end
            if (wr_list) list <= reg_wdata[LIST_W-1:0];
            if (wr_div && !run) div <= reg_wdata[DIV_W-1:0];
            if (wr_ien) ien_q <= reg_wdata[NUM_CH-1:0];
            stat_q <= (stat_q & ~clr_mask) | (evt.wrap ? set_mask : '0);
            ovr_q  <= (ovr_q & !(wr_stat && reg_wdata[OVR_BIT])) | evt.ovr;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[RUN_BIT] = run;
                reg_rdata[LAST_LSB +: CH_W] = last;
            end
            ADR_LIST: reg_rdata[LIST_W-1:0] = list;
            ADR_DIV:  reg_rdata[DIV_W-1:0] = div;
            ADR_STAT: begin
                reg_rdata[NUM_CH-1:0] = stat_q;
                reg_rdata[OVR_BIT] = ovr_q;
            end
            ADR_IEN:  reg_rdata[NUM_CH-1:0] = ien_q;
            ADR_OFS:  reg_rdata[OFS_W-1:0] = ofs;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int DIV_W   = 32,
    parameter int GAP_CYC = 400,
    parameter int OFS_W   = 12,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               conv_req,
    output logic [CH_W-1:0]    conv_ch,
    input  logic               conv_done,
    output logic [OFS_W-1:0]   buf_offset,
    output logic               irq
);
    logic                   run_w, start_w, trig_w;
    logic [CH_W-1:0]        last_w;
    logic [NUM_CH*CH_W-1:0] list_w;
    logic [DIV_W-1:0]       div_w;
    scan_evt_t              evt_w;

    acq_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DIV_W(DIV_W), .OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ofs(buf_offset), .evt(evt_w),
        .run(run_w), .start(start_w), .last(last_w), .list(list_w), .div(div_w), .irq(irq)
    );

    acq_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst(rst), .run(run_w), .start(start_w), .div(div_w), .trig(trig_w)
    );

    acq_scan #(.NUM_CH(NUM_CH), .CH_W(CH_W), .GAP_CYC(GAP_CYC), .OFS_W(OFS_W)) u_scan (
        .clk(clk), .rst(rst), .run(run_w), .start(start_w), .trig(trig_w),
        .div_zero(div_w == '0), .last(last_w), .list(list_w),
        .conv_done(conv_done), .conv_req(conv_req), .conv_ch(conv_ch),
        .ofs(buf_offset), .evt(evt_w)
    );
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
    parameter int GAP_CYC = 400,
    parameter int OFS_W   = 12,
    parameter int DIV_W   = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic             conv_req,
    input logic [OFS_W-1:0] buf_offset,
    input logic             irq,
    input logic             run,
    input logic [DIV_W-1:0] div
);
    localparam int SW = $clog2(GAP_CYC + 1);
    localparam logic [SW-1:0] SAT = SW'(GAP_CYC);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) since_q <= SAT;
        else if (conv_req) since_q <= SW'(1);
        else if (since_q < SAT) since_q <= since_q + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!conv_req && buf_offset == '0 && !irq));

    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

    assert_sample_gap_R4: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> since_q >= SAT);

    assert_div_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd2 && run) |=> $stable(div));

    assert_offset_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_offset) |-> buf_offset == $past(buf_offset) + 1'b1);

    assert_stopped_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !conv_req);
endmodule

bind acq_sequencer acq_sequencer_chk #(.GAP_CYC(GAP_CYC), .OFS_W(OFS_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .conv_req(conv_req),
    .buf_offset(buf_offset), .irq(irq), .run(run_w), .div(div_w)
);

// File: tb/sim_acq_sequencer.sv
module sim_acq_sequencer;
    localparam int GAP = 5;
    localparam int OW  = 12;
    localparam int A_CTRL = 0, A_LIST = 1, A_DIV = 2, A_STAT = 3, A_IEN = 4, A_OFS = 5;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        conv_req, conv_done = 1'b0, irq;
    logic [2:0]  conv_ch;
    logic [OW-1:0] buf_offset;

    acq_sequencer #(.NUM_CH(8), .DIV_W(32), .GAP_CYC(GAP), .OFS_W(OW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
        .buf_offset(buf_offset), .irq(irq)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, wr_edge = 0;
    int nlog = 0, ofs_bad = 0, n_wrap = 0, prev_ofs = 0;
    int log_t [64];
    int log_c [64];
    int ent [8] = '{3, 5, 0, 7, 1, 2, 4, 6};

    always @(posedge clk) cyc <= cyc + 1;

    // converter model: done one cycle after each request
    always @(negedge clk) conv_done = conv_req;

    always @(negedge clk) begin
        if (conv_req) begin
            if (nlog < 64) begin
                log_t[nlog] = cyc;
                log_c[nlog] = int'(conv_ch);
            end
            nlog++;
        end
        if (int'(buf_offset) != prev_ofs) begin
            if (int'(buf_offset) != (prev_ofs + 1) % (1 << OW)) ofs_bad++;
            if (buf_offset == '0) n_wrap++;
            prev_ofs = int'(buf_offset);
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d; wr_edge = cyc + 1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] list_word(input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) w[k*3 +: 3] = 3'(ent[k]);
        return w;
    endfunction

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int e0, e1, bad, mn;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R1 register reset", d, 0);
        end
        check("R1 conv_req", conv_req, 0);
        check("R1 irq", irq, 0);
        check("R1 offset", buf_offset, 0);

        // R2 R4 R5 normal pacing: DIV=39, 3 entries
        wr(A_LIST, list_word(8));
        wr(A_DIV, 39);
        nlog = 0;
        wr(A_CTRL, 32'h1 | (32'd2 << 4));
        e0 = wr_edge;
        repeat (140) @(negedge clk);
        check("R2 request count", nlog, 9);
        check("R2 first request delay", log_t[0] - e0, 41);
        for (int k = 1; k < 9; k++)
            check("R2 R4 request timing", log_t[k] - log_t[0], (k / 3) * 40 + (k % 3) * GAP);
        bad = 0;
        for (int k = 0; k < 9; k++) if (log_c[k] != ent[k % 3]) bad++;
        check("R5 channel order", bad, 0);
        rd(A_OFS, d);
        check("R8 offset after 3 scans", d, 3);
        rd(A_STAT, d);
        check("R7 no overrun", d[8], 0);

        // R3 divider locked while running
        wr(A_DIV, 7);
        rd(A_DIV, d);
        check("R3 locked divider", d, 39);
        nlog = 0;
        repeat (85) @(negedge clk);
        check("R3 count after write", nlog, 6);
        check("R3 period kept", log_t[3] - log_t[0], 40);

        // R12 stop
        wr(A_CTRL, 32'd2 << 4);
        nlog = 0;
        repeat (100) @(negedge clk);
        check("R12 no requests when stopped", nlog, 0);
        wr(A_DIV, 7);
        rd(A_DIV, d);
        check("R3 divider writable when stopped", d, 7);

        // R7 overrun with DIV=7 and a 3-entry list
        nlog = 0;
        wr(A_CTRL, 32'h1 | (32'd2 << 4));
        repeat (60) @(negedge clk);
        wr(A_CTRL, 32'd2 << 4);
        mn = 1000;
        for (int k = 1; k < nlog && k < 64; k++) if (log_t[k] - log_t[k-1] < mn) mn = log_t[k] - log_t[k-1];
        check("R4 min spacing under overrun", mn, GAP);
        rd(A_STAT, d);
        check("R7 overrun set", d[8], 1);
        check("R9 no channel status yet", d[7:0], 0);
        wr(A_STAT, 32'h100);
        rd(A_STAT, d);
        check("R7 overrun cleared", d[8], 0);

        // R6 R8 R9 R10 fastest mode and wrap
        wr(A_LIST, 32'd6 | (32'd1 << 3));
        wr(A_DIV, 0);
        nlog = 0;
        wr(A_CTRL, 32'h1 | (32'd1 << 4));
        repeat (60) @(negedge clk);
        bad = 0;
        for (int k = 1; k < nlog && k < 64; k++) if (log_t[k] - log_t[k-1] != GAP) bad++;
        check("R6 back-to-back spacing", bad, 0);
        bad = 0;
        for (int k = 0; k < nlog && k < 64; k++) if (log_c[k] != ((k % 2) == 0 ? 6 : 1)) bad++;
        check("R5 R6 channel alternation", bad, 0);
        rd(A_STAT, d);
        check("R6 no overrun", d[8], 0);
        for (int i = 0; i < 60000 && n_wrap == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'd1 << 4);
        check("R8 wrap seen", n_wrap, 1);
        check("R8 offset steps", ofs_bad, 0);
        rd(A_STAT, d);
        check("R9 status on wrap", d[7:0], 8'h42);
        check("R10 irq masked", irq, 0);
        wr(A_IEN, 32'h04);
        check("R10 irq other enable", irq, 0);
        wr(A_IEN, 32'h02);
        check("R10 irq enabled", irq, 1);
        wr(A_STAT, 32'h40);
        rd(A_STAT, d);
        check("R9 partial clear", d[7:0], 8'h02);
        check("R10 irq still set", irq, 1);
        wr(A_STAT, 32'h02);
        rd(A_STAT, d);
        check("R9 full clear", d[7:0], 0);
        check("R10 irq cleared", irq, 0);

        // R11 restart mid-scan begins at entry 0
        wr(A_LIST, list_word(8));
        wr(A_DIV, 100);
        nlog = 0;
        wr(A_CTRL, 32'h1 | (32'd2 << 4));
        for (int i = 0; i < 300 && nlog == 0; i++) @(negedge clk);
        wr(A_CTRL, 32'd2 << 4);
        wr(A_CTRL, 32'h1 | (32'd2 << 4));
        e1 = wr_edge;
        repeat (110) @(negedge clk);
        check("R11 restart delay", log_t[1] - e1, 102);
        check("R11 restart entry 0", log_c[1], 3);
        check("R11 second entry", log_c[2], 5);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule